// File: doc/BRIEF.md
# Watchpoint Value Register Access Gate

This block decides, in a single combinational pass, what happens when a system-register instruction tries to read or write one of the banked watchpoint address registers. It takes the decoded instruction fields, a read/write flag, the current exception level, a bank selector and the trap, lock and disable controls owned by the higher exception levels. It reports exactly one outcome: allowed, undefined, trap to EL2, trap to EL3 or debug halt.

It also reports the resolved register index and a constant syndrome class for traps. The number of implemented watchpoints and the presence of EL2, EL3, fine-grained traps and register banking are elaboration parameters. The surrounding core uses the outcome to raise the exception or to steer the access into the register file. Storage and exception entry stay outside this block.

Top module: `wva_access_gate`

## Requirements
- R1: The instruction is recognised only when op0=2'b10, op1=3'b000, crn=4'b0000 and op2=3'b110. Otherwise `enc_hit` is 0 and `outcome` is 5'b00000.
- R2: With banking present, `reg_idx` equals crm + 16*bank_sel. Without banking, it equals crm and bank_sel is ignored.
- R3: An index at or above NUM_WP makes the access undefined at every exception level. This check has the highest priority.
- R4: A recognised access from EL0 (cur_el=0) is undefined.
- R5: At EL1 or EL2, the access is undefined when EL3 exists and both `sec_undef_prio` and `sec_trap_dbg` are 1. This check comes ahead of every trap.
- R6: At EL1, the access traps to EL2 under all of these conditions: EL2 is enabled, fine-grained traps exist, EL3 is absent or `sec_fgt_en`=1, and the fine-grained bit for the direction is set. Reads use `fgt_rd_trap` and writes (is_write=1) use `fgt_wr_trap`.
- R7: At EL1, after R6, the access traps to EL2 when EL2 is enabled and either `hyp_trap_exc` or `hyp_trap_dbg` is 1.
- R8: At EL1 or EL2, after the checks above, `sec_trap_dbg`=1 (with EL3 present) gives undefined when `sec_undef` is 1, and a trap to EL3 otherwise.
- R9: When no earlier check fires, the result is a debug halt if `os_lock` is 0, `halt_ok` is 1 and `ext_trap_dbg` is 1. In every other case the access is allowed.
- R10: At EL2 (cur_el=2), the fine-grained and coarse EL2 traps are never taken.
- R11: At EL3 (cur_el=3), only the range check and the halt check can change the result.
- R12: A recognised access asserts exactly one outcome bit: bit0 allowed, bit1 undefined, bit2 trap to EL2, bit3 trap to EL3, bit4 halt. `syn_class` is always 6'h18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op0 | input | 2 | Instruction op0 field |
| op1 | input | 3 | Instruction op1 field |
| crn | input | 4 | Instruction CRn field |
| crm | input | 4 | Register number within the bank |
| op2 | input | 3 | Instruction op2 field |
| is_write | input | 1 | 1 for a write, 0 for a read |
| cur_el | input | 2 | Current exception level |
| bank_sel | input | BANK_W | Register bank selector |
| el2_on | input | 1 | EL2 is enabled in the current state |
| sec_undef_prio | input | 1 | EL3 secure-disable undefined takes priority |
| sec_undef | input | 1 | EL3 secure-disable turns the EL3 trap into undefined |
| sec_trap_dbg | input | 1 | EL3 traps debug register access |
| sec_fgt_en | input | 1 | EL3 enables fine-grained traps |
| fgt_rd_trap | input | 1 | Fine-grained read trap bit |
| fgt_wr_trap | input | 1 | Fine-grained write trap bit |
| hyp_trap_exc | input | 1 | EL2 routes debug exceptions |
| hyp_trap_dbg | input | 1 | EL2 traps debug register access |
| os_lock | input | 1 | OS lock is set |
| halt_ok | input | 1 | Halting is allowed |
| ext_trap_dbg | input | 1 | External debugger traps register access |
| enc_hit | output | 1 | Instruction encoding recognised |
| outcome | output | 5 | One-hot outcome |
| reg_idx | output | 4+BANK_W | Resolved register index |
| syn_class | output | 6 | Syndrome class reported for traps |

## Verification
Random stimulus makes most instructions match the encoding. It spreads the exception level, bank, direction and every control bit evenly. This makes sure each step of the priority chain is the first to fire many times. Directed cases then separate neighbouring priorities. Range undefined is set against halt, secure-priority undefined against the fine-grained trap, and the fine-grained trap against the coarse trap. The undefined and trap-to-EL3 branches of the EL3 access trap are tried, as is the read bit against the write bit. Index boundary values (39 against 40) and the EL2 and EL3 cases with every trap control raised show that the skipped checks stay silent.

// File: rtl/wva_pkg.sv
package wva_pkg;
  typedef enum logic [4:0] {
    OC_NONE  = 5'b00000,
    OC_ALLOW = 5'b00001,
    OC_UNDEF = 5'b00010,
    OC_HYP   = 5'b00100,
    OC_SEC   = 5'b01000,
    OC_HALT  = 5'b10000
  } outcome_e;

  localparam logic [1:0] ENC_OP0 = 2'b10;
  localparam logic [2:0] ENC_OP1 = 3'b000;
  localparam logic [3:0] ENC_CRN = 4'b0000;
  localparam logic [2:0] ENC_OP2 = 3'b110;
  localparam logic [5:0] SYN_DBG_ACCESS = 6'h18;
  localparam int unsigned REGS_PER_BANK = 16;
endpackage

// File: rtl/wva_enc_match.sv
module wva_enc_match
  import wva_pkg::*;
(
  input  logic [1:0] op0,
  input  logic [2:0] op1,
  input  logic [3:0] crn,
  input  logic [2:0] op2,
  output logic       hit
);
  always_comb begin
    hit = (op0 == ENC_OP0) && (op1 == ENC_OP1) &&
          (crn == ENC_CRN) && (op2 == ENC_OP2);
  end
endmodule

// File: rtl/wva_bank_index.sv
module wva_bank_index #(
  parameter int unsigned NUM_WP   = 40,
  parameter bit          HAS_BANK = 1'b1,
  parameter int unsigned BANK_W   = 2,
  localparam int unsigned IDX_W   = 4 + BANK_W
) (
  input  logic [3:0]        crm,
  input  logic [BANK_W-1:0] bank_sel,
  output logic [IDX_W-1:0]  idx,
  output logic              idx_ok
);
  generate
    if (HAS_BANK) begin : g_banked
      assign idx = {bank_sel, crm};
    end else begin : g_flat
      logic unused_bank;
      assign unused_bank = ^bank_sel;
      assign idx = {{BANK_W{1'b0}}, crm};
    end
  endgenerate

  always_comb begin
    idx_ok = (32'(idx) < NUM_WP);
  end
endmodule

// File: rtl/wva_prio_chain.sv
module wva_prio_chain
  import wva_pkg::*;
#(
  parameter bit HAS_EL2 = 1'b1,
  parameter bit HAS_EL3 = 1'b1,
  parameter bit HAS_FGT = 1'b1
) (
  input  logic     hit,
  input  logic     idx_ok,
  input  logic     is_write,
  input  logic [1:0] cur_el,
  input  logic     el2_on,
  input  logic     sec_undef_prio,
  input  logic     sec_undef,
  input  logic     sec_trap_dbg,
  input  logic     sec_fgt_en,
  input  logic     fgt_rd_trap,
  input  logic     fgt_wr_trap,
  input  logic     hyp_trap_exc,
  input  logic     hyp_trap_dbg,
  input  logic     os_lock,
  input  logic     halt_ok,
  input  logic     ext_trap_dbg,
  output outcome_e outcome
);
  logic hyp_live, sec_prio_undef, fgt_fire, coarse_fire, sec_fire, halt_fire;

  always_comb begin
    hyp_live       = HAS_EL2 && el2_on;
    sec_prio_undef = HAS_EL3 && sec_undef_prio && sec_trap_dbg;
    fgt_fire       = hyp_live && HAS_FGT && (!HAS_EL3 || sec_fgt_en) &&
                     (is_write ? fgt_wr_trap : fgt_rd_trap);
    coarse_fire    = hyp_live && (hyp_trap_exc || hyp_trap_dbg);
    sec_fire       = HAS_EL3 && sec_trap_dbg;
    halt_fire      = !os_lock && halt_ok && ext_trap_dbg;
  end

  always_comb begin
    outcome = OC_NONE;
    if (hit) begin
      if (!idx_ok)                        outcome = OC_UNDEF;
      else if (cur_el == 2'd0)            outcome = OC_UNDEF;
      else if (cur_el == 2'd3)            outcome = halt_fire ? OC_HALT : OC_ALLOW;
      else if (sec_prio_undef)            outcome = OC_UNDEF;
      else if (cur_el == 2'd1 && fgt_fire)    outcome = OC_HYP;
      else if (cur_el == 2'd1 && coarse_fire) outcome = OC_HYP;
      else if (sec_fire)                  outcome = sec_undef ? OC_UNDEF : OC_SEC;
      else if (halt_fire)                 outcome = OC_HALT;
      else                                outcome = OC_ALLOW;
    end
  end
endmodule

// File: rtl/wva_access_gate.sv
module wva_access_gate
  import wva_pkg::*;
#(
  parameter int unsigned NUM_WP   = 40,
  parameter bit          HAS_EL2  = 1'b1,
  parameter bit          HAS_EL3  = 1'b1,
  parameter bit          HAS_FGT  = 1'b1,
  parameter bit          HAS_BANK = 1'b1,
  parameter int unsigned BANK_W   = 2,
  localparam int unsigned IDX_W   = 4 + BANK_W
) (
  input  logic [1:0]        op0,
  input  logic [2:0]        op1,
  input  logic [3:0]        crn,
  input  logic [3:0]        crm,
  input  logic [2:0]        op2,
  input  logic              is_write,
  input  logic [1:0]        cur_el,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              el2_on,
  input  logic              sec_undef_prio,
  input  logic              sec_undef,
  input  logic              sec_trap_dbg,
  input  logic              sec_fgt_en,
  input  logic              fgt_rd_trap,
  input  logic              fgt_wr_trap,
  input  logic              hyp_trap_exc,
  input  logic              hyp_trap_dbg,
  input  logic              os_lock,
  input  logic              halt_ok,
  input  logic              ext_trap_dbg,
  output logic              enc_hit,
  output logic [4:0]        outcome,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [5:0]        syn_class
);
  logic     idx_ok;
  outcome_e chain_oc;

  wva_enc_match i_match (
    .op0(op0), .op1(op1), .crn(crn), .op2(op2), .hit(enc_hit)
  );

  wva_bank_index #(
    .NUM_WP(NUM_WP), .HAS_BANK(HAS_BANK), .BANK_W(BANK_W)
  ) i_index (
    .crm(crm), .bank_sel(bank_sel), .idx(reg_idx), .idx_ok(idx_ok)
  );

  wva_prio_chain #(
    .HAS_EL2(HAS_EL2), .HAS_EL3(HAS_EL3), .HAS_FGT(HAS_FGT)
  ) i_chain (
    .hit(enc_hit), .idx_ok(idx_ok), .is_write(is_write), .cur_el(cur_el),
    .el2_on(el2_on), .sec_undef_prio(sec_undef_prio), .sec_undef(sec_undef),
    .sec_trap_dbg(sec_trap_dbg), .sec_fgt_en(sec_fgt_en),
    .fgt_rd_trap(fgt_rd_trap), .fgt_wr_trap(fgt_wr_trap),
    .hyp_trap_exc(hyp_trap_exc), .hyp_trap_dbg(hyp_trap_dbg),
    .os_lock(os_lock), .halt_ok(halt_ok), .ext_trap_dbg(ext_trap_dbg),
    .outcome(chain_oc)
  );

  assign outcome   = chain_oc;
  assign syn_class = SYN_DBG_ACCESS;

  always_comb begin
    if (!$isunknown({op0, op1, crn, crm, op2, cur_el, bank_sel, outcome, enc_hit, idx_ok})) begin
      a_r12_onehot: assert (!enc_hit || $onehot(outcome));
      a_r1_nomatch: assert (enc_hit || outcome == 5'b0);
      a_r3_range: assert (!(outcome == 5'b00001 || outcome == 5'b10000) || idx_ok);
      a_r4_el0: assert (!(enc_hit && cur_el == 2'd0) || outcome == 5'b00010);
      a_r11_el3_quiet: assert (!(enc_hit && cur_el == 2'd3) ||
                               (outcome != 5'b00100 && outcome != 5'b01000));
    end
  end
endmodule

// File: tb/test_wva_access_gate.sv
module test_wva_access_gate;
  localparam int unsigned NUM_WP = 40;
  localparam int unsigned BANK_W = 2;
  localparam logic [4:0] E_NONE = 5'b00000, E_ALLOW = 5'b00001, E_UNDEF = 5'b00010,
                         E_HYP = 5'b00100, E_SEC = 5'b01000, E_HALT = 5'b10000;

  logic clk;
  logic [1:0] op0; logic [2:0] op1; logic [3:0] crn; logic [3:0] crm; logic [2:0] op2;
  logic is_write; logic [1:0] cur_el; logic [BANK_W-1:0] bank_sel;
  logic el2_on, sec_undef_prio, sec_undef, sec_trap_dbg, sec_fgt_en;
  logic fgt_rd_trap, fgt_wr_trap, hyp_trap_exc, hyp_trap_dbg;
  logic os_lock, halt_ok, ext_trap_dbg;
  logic enc_hit; logic [4:0] outcome; logic [5:0] reg_idx; logic [5:0] syn_class;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  wva_access_gate i_wva_access_gate (
    .op0(op0), .op1(op1), .crn(crn), .crm(crm), .op2(op2), .is_write(is_write),
    .cur_el(cur_el), .bank_sel(bank_sel), .el2_on(el2_on),
    .sec_undef_prio(sec_undef_prio), .sec_undef(sec_undef), .sec_trap_dbg(sec_trap_dbg),
    .sec_fgt_en(sec_fgt_en), .fgt_rd_trap(fgt_rd_trap), .fgt_wr_trap(fgt_wr_trap),
    .hyp_trap_exc(hyp_trap_exc), .hyp_trap_dbg(hyp_trap_dbg), .os_lock(os_lock),
    .halt_ok(halt_ok), .ext_trap_dbg(ext_trap_dbg), .enc_hit(enc_hit),
    .outcome(outcome), .reg_idx(reg_idx), .syn_class(syn_class)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [4:0] ref_oc(output string tag);
    logic hit; int idx; logic halt;
    hit  = (op0 == 2'b10) && (op1 == 3'b000) && (crn == 4'b0000) && (op2 == 3'b110);
    idx  = int'(crm) + 16 * int'(bank_sel);
    halt = !os_lock && halt_ok && ext_trap_dbg;
    if (!hit) begin tag = "R1"; return E_NONE; end
    if (idx >= NUM_WP) begin tag = "R3"; return E_UNDEF; end
    if (cur_el == 0) begin tag = "R4"; return E_UNDEF; end
    if (cur_el == 3) begin tag = "R11"; return halt ? E_HALT : E_ALLOW; end
    if (sec_undef_prio && sec_trap_dbg) begin tag = "R5"; return E_UNDEF; end
    if (cur_el == 1 && el2_on && sec_fgt_en && (is_write ? fgt_wr_trap : fgt_rd_trap)) begin
      tag = "R6"; return E_HYP;
    end
    if (cur_el == 1 && el2_on && (hyp_trap_exc || hyp_trap_dbg)) begin tag = "R7"; return E_HYP; end
    if (sec_trap_dbg) begin tag = "R8"; return sec_undef ? E_UNDEF : E_SEC; end
    tag = (cur_el == 2) ? "R10" : "R9";
    return halt ? E_HALT : E_ALLOW;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic baseline();
    op0 = 2'b10; op1 = 3'b000; crn = 4'b0000; op2 = 3'b110; crm = 4'd0;
    is_write = 0; cur_el = 2'd1; bank_sel = '0; el2_on = 0; sec_undef_prio = 0;
    sec_undef = 0; sec_trap_dbg = 0; sec_fgt_en = 0; fgt_rd_trap = 0; fgt_wr_trap = 0;
    hyp_trap_exc = 0; hyp_trap_dbg = 0; os_lock = 0; halt_ok = 0; ext_trap_dbg = 0;
  endtask

  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic randomize_inputs();
    if ($urandom_range(3) != 0) begin
      op0 = 2'b10; op1 = 3'b000; crn = 4'b0000; op2 = 3'b110;
    end else begin
      op0 = 2'($urandom); op1 = 3'($urandom); crn = 4'($urandom); op2 = 3'($urandom);
    end
    crm = 4'($urandom); bank_sel = BANK_W'($urandom); is_write = 1'($urandom);
    cur_el = 2'($urandom); el2_on = 1'($urandom); sec_undef_prio = 1'($urandom);
    sec_undef = 1'($urandom); sec_trap_dbg = 1'($urandom); sec_fgt_en = 1'($urandom);
    fgt_rd_trap = 1'($urandom); fgt_wr_trap = 1'($urandom); hyp_trap_exc = 1'($urandom);
    hyp_trap_dbg = 1'($urandom); os_lock = 1'($urandom); halt_ok = 1'($urandom);
    ext_trap_dbg = 1'($urandom);
  endtask

  initial begin
    string tag;
    logic [4:0] exp;
    void'($urandom(32'h5eed_0042));
    baseline();
    settle();
    check("R9 idle allow", 32'(outcome), 32'(E_ALLOW));
    check("R2 idle index", 32'(reg_idx), 0);
    check("R12 syndrome", 32'(syn_class), 32'h18);

    op2 = 3'b111; settle();
    check("R1 no match hit", 32'(enc_hit), 0);
    check("R1 no match outcome", 32'(outcome), 32'(E_NONE));
    baseline(); crn = 4'b0001; settle();
    check("R1 crn mismatch", 32'(outcome), 32'(E_NONE));

    baseline(); crm = 4'd5; bank_sel = 2'd2; settle();
    check("R2 banked index", 32'(reg_idx), 37);
    check("R2 banked allow", 32'(outcome), 32'(E_ALLOW));
    crm = 4'd7; settle();
    check("R3 index 39 in range", 32'(outcome), 32'(E_ALLOW));
    crm = 4'd8; halt_ok = 1; ext_trap_dbg = 1; settle();
    check("R3 index 40 undef", 32'(outcome), 32'(E_UNDEF));
    cur_el = 2'd3; settle();
    check("R3 out of range at EL3", 32'(outcome), 32'(E_UNDEF));

    baseline(); cur_el = 2'd0; settle();
    check("R4 EL0 undef", 32'(outcome), 32'(E_UNDEF));

    baseline(); sec_undef_prio = 1; sec_trap_dbg = 1; el2_on = 1; sec_fgt_en = 1;
    fgt_rd_trap = 1; settle();
    check("R5 priority undef over trap", 32'(outcome), 32'(E_UNDEF));

    baseline(); el2_on = 1; sec_fgt_en = 1; fgt_rd_trap = 1; sec_trap_dbg = 1; settle();
    check("R6 read fine trap", 32'(outcome), 32'(E_HYP));
    baseline(); el2_on = 1; sec_fgt_en = 1; fgt_rd_trap = 1; is_write = 1; settle();
    check("R6 write ignores read bit", 32'(outcome), 32'(E_ALLOW));
    fgt_wr_trap = 1; settle();
    check("R6 write fine trap", 32'(outcome), 32'(E_HYP));
    sec_fgt_en = 0; settle();
    check("R6 gated by EL3 enable", 32'(outcome), 32'(E_ALLOW));

    baseline(); el2_on = 1; hyp_trap_exc = 1; settle();
    check("R7 coarse trap exc", 32'(outcome), 32'(E_HYP));
    hyp_trap_exc = 0; hyp_trap_dbg = 1; settle();
    check("R7 coarse trap dbg", 32'(outcome), 32'(E_HYP));
    el2_on = 0; settle();
    check("R7 EL2 disabled", 32'(outcome), 32'(E_ALLOW));

    baseline(); sec_trap_dbg = 1; halt_ok = 1; ext_trap_dbg = 1; settle();
    check("R8 trap to EL3", 32'(outcome), 32'(E_SEC));
    sec_undef = 1; settle();
    check("R8 secure disable undef", 32'(outcome), 32'(E_UNDEF));

    baseline(); halt_ok = 1; ext_trap_dbg = 1; settle();
    check("R9 halt", 32'(outcome), 32'(E_HALT));
    os_lock = 1; settle();
    check("R9 OS lock blocks halt", 32'(outcome), 32'(E_ALLOW));

    baseline(); cur_el = 2'd2; el2_on = 1; sec_fgt_en = 1; fgt_rd_trap = 1;
    hyp_trap_exc = 1; hyp_trap_dbg = 1; settle();
    check("R10 EL2 skips EL2 traps", 32'(outcome), 32'(E_ALLOW));
    sec_trap_dbg = 1; settle();
    check("R10 EL2 still takes EL3 trap", 32'(outcome), 32'(E_SEC));

    baseline(); cur_el = 2'd3; el2_on = 1; sec_trap_dbg = 1; sec_undef_prio = 1;
    hyp_trap_dbg = 1; fgt_rd_trap = 1; sec_fgt_en = 1; settle();
    check("R11 EL3 ignores traps", 32'(outcome), 32'(E_ALLOW));
    halt_ok = 1; ext_trap_dbg = 1; settle();
    check("R11 EL3 halt", 32'(outcome), 32'(E_HALT));

    for (int i = 0; i < 3000; i++) begin
      randomize_inputs();
      settle();
      exp = ref_oc(tag);
      check(tag, 32'(outcome), 32'(exp));
      check("R2", 32'(reg_idx), 32'(int'(crm) + 16 * int'(bank_sel)));
      check("R12", 32'($countones(outcome)), (exp == E_NONE) ? 0 : 1);
    end
    done = 1;
  end

  initial begin
    int cycles = 0;
    while (!done && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule